// File: doc/BRIEF.md
# Divided Countdown Timer

This block is the countdown timer of an interrupt controller. A free-running phase counter splits the core clock into 16-clock units. A second stage divides those units by a power of two chosen in a 4-bit configuration register. Each divided tick takes one off the current count. When the count goes from one to zero, a single-cycle expiry pulse goes to the interrupt logic. The count then rests at zero until software loads a new value.

Software uses one write port and one combinational read port. Each port has a 2-bit register select. Select 0 is the divide configuration, 1 is the initial count, 2 is the remaining count (read-only), and 3 is an empty slot. The timer does not reload itself. A new countdown starts only when the initial count is written again.

Top module: `divtick_timer`

## Requirements
- R1: The divisor comes from configuration bits 3, 1 and 0, taken as a 3-bit code with bit 3 as the most significant. The shift is (code + 1) mod 8 and the divisor is 2 to the power of the shift. Code 000 divides by 2, code 110 by 128 and code 111 by 1.
- R2: A write with select 0 stores only data bits 3, 1 and 0. Bits 2 and 31..4 are stored as zero, and reading select 0 returns the stored value.
- R3: While a countdown runs, successive decrements of the remaining count are exactly 16 × divisor clocks apart.
- R4: A write with select 1 stores the full 32-bit value, and select 1 reads it back. The remaining count takes that value at the same edge, and any countdown in progress is abandoned.
- R5: The 16-clock phase counter starts at reset release. Every 16th clock edge after release is a boundary edge. If the initial-count write happens on a boundary edge, the first decrement comes 16 × divisor edges later. If it does not, the edges up to the next boundary are waited out first, and then 16 × divisor more edges pass.
- R6: Writes with select 2 do not change the remaining count.
- R7: Reading select 2 returns the remaining count in divided ticks.
- R8: `expire` is high for exactly one clock. That clock starts at the edge where the remaining count goes from 1 to 0. After it, the count stays at zero until the next initial-count write.
- R9: Loading an initial count of zero stops the timer at once, and no expiry pulse follows.
- R10: A synchronous active-high reset clears the configuration, the initial count and the remaining count, and holds `expire` low.
- R11: Select 3 reads as zero, and writes to it have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write register select (0 cfg, 1 initial, 2 remaining, 3 empty) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select, same encoding |
| rd_data | output | 32 | Combinational read data |
| expire | output | 1 | One-cycle expiry pulse |

## Verification
A behavioural model of the timer is compared with the block on every clock, using edge arithmetic only. The countdown is run at divisors 1, 2, 16 and 128, which separates the three decode bits and the wrap-around of the shift. Some loads are placed on a boundary edge and some off it, which separates the aligned and partial first-tick delays. Reloads during a countdown and zero loads show that a countdown is cancelled, and writes to the read-only and empty selects show that they are ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CFG_W = 4;
    localparam logic [CFG_W-1:0] CFG_KEEP = 4'b1011;

    typedef enum logic [1:0] {
        SEL_DIVCFG = 2'd0,
        SEL_LOAD   = 2'd1,
        SEL_REMAIN = 2'd2,
        SEL_EMPTY  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic cfg_we;
        logic load_we;
    } wr_dec_t;

    // Shift amount from the sparse code {b3,b1,b0}; 3-bit add wraps mod 8.
    function automatic logic [2:0] div_shift(input logic [CFG_W-1:0] cfg);
        return 3'({cfg[3], cfg[1], cfg[0]} + 3'd1);
    endfunction

    function automatic wr_dec_t decode_wr(input logic en, input reg_sel_e sel);
        wr_dec_t d;
        d.cfg_we  = en && (sel == SEL_DIVCFG);
        d.load_we = en && (sel == SEL_LOAD);
        return d;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PRE_LOG = 4
) (
    input  logic clk,
    input  logic rst,
    output logic base_strobe
);
    logic [PRE_LOG-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Boundary edge: the phase wraps to zero at this edge.
    assign base_strobe = &phase_q;
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               base_strobe,
    input  logic [SHIFT_W-1:0] shift,
    output logic               dec_pulse
);
    localparam int SUB_W = (1 << SHIFT_W) - 1;
    localparam int DIV_W = SUB_W + 1;

    logic [SUB_W-1:0] sub_q;
    logic             skip_q;
    logic [DIV_W-1:0] div_full;
    logic             last_unit;

    assign div_full  = DIV_W'(1) << shift;
    assign last_unit = ({1'b0, sub_q} >= (div_full - DIV_W'(1)));
    assign dec_pulse = base_strobe && !restart && !skip_q && last_unit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q  <= '0;
            skip_q <= 1'b0;
        end else if (restart) begin
            sub_q  <= '0;
            skip_q <= !base_strobe;
        end else if (base_strobe) begin
            if (skip_q) begin
                skip_q <= 1'b0;
            end else if (last_unit) begin
                sub_q <= '0;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/count_core.sv
module count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            expire <= 1'b0;
        end else if (load) begin
            cur    <= load_val;
            expire <= 1'b0;
        end else if (dec && (cur != '0)) begin
            cur    <= cur - 1'b1;
            expire <= (cur == CNT_W'(1));
        end else begin
            expire <= 1'b0;
        end
    end
endmodule

// File: rtl/divtick_timer.sv
module divtick_timer #(
    parameter int CNT_W   = 32,
    parameter int PRE_LOG = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             expire
);
    import tmr_pkg::*;

    localparam int SHIFT_W = 3;

    wr_dec_t                 wdec;
    logic                    load_we;
    logic [CFG_W-1:0]        cfg_q;
    logic [CNT_W-1:0]        init_q;
    logic [CNT_W-1:0]        cur_cnt;
    logic                    base_strobe;
    logic                    dec_pulse;

    assign wdec    = decode_wr(wr_en, reg_sel_e'(wr_sel));
    assign load_we = wdec.load_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            init_q <= '0;
        end else begin
            if (wdec.cfg_we)  cfg_q  <= wr_data[CFG_W-1:0] & CFG_KEEP;
            if (wdec.load_we) init_q <= wr_data;
        end
    end

    tick_prescaler #(.PRE_LOG(PRE_LOG)) u_pre (
        .clk         (clk),
        .rst         (rst),
        .base_strobe (base_strobe)
    );

    tick_divider #(.SHIFT_W(SHIFT_W)) u_div (
        .clk         (clk),
        .rst         (rst),
        .restart     (load_we),
        .base_strobe (base_strobe),
        .shift       (div_shift(cfg_q)),
        .dec_pulse   (dec_pulse)
    );

    count_core #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load_we),
        .load_val (wr_data),
        .dec      (dec_pulse),
        .cur      (cur_cnt),
        .expire   (expire)
    );

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_DIVCFG: rd_data = {{(CNT_W-CFG_W){1'b0}}, cfg_q};
            SEL_LOAD:   rd_data = init_q;
            SEL_REMAIN: rd_data = cur_cnt;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic             dec,
    input logic [CNT_W-1:0] cur,
    input logic [3:0]       cfg,
    input logic             expire,
    input logic [CNT_W-1:0] wdata
);
    // R8
    expire_single_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

    // R8
    expire_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        expire |-> (cur == '0));

    // R8
    zero_rest_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == '0) && !load |=> (cur == '0) && !expire);

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        dec && !load && (cur != '0) |=> cur == $past(cur) - 1'b1);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load && !dec |=> $stable(cur));

    // R4
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cur == $past(wdata));

    // R2
    cfg_sparse_chk: assert property (@(posedge clk) disable iff (rst)
        cfg[2] == 1'b0);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cur == '0) && (cfg == 4'h0) && !expire);
endmodule

bind divtick_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .load   (load_we),
    .dec    (dec_pulse),
    .cur    (cur_cnt),
    .cfg    (cfg_q),
    .expire (expire),
    .wdata  (wr_data)
);

// File: tb/sim_divtick_timer.sv
`timescale 1ns/1ps
module sim_divtick_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_sel = 2'd2;
    logic [31:0] rd_data;
    logic        expire;

    int n_chk = 0;
    int n_bad = 0;
    int n_exp = 0;
    bit run = 1'b0;
    bit done = 1'b0;

    longint      m_e, m_next;
    logic [31:0] m_cur, m_init;
    logic [3:0]  m_cfg;
    bit          m_exp;

    always #10 clk = ~clk;

    divtick_timer u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .expire(expire));

    function automatic longint mdiv(input logic [3:0] c);
        int code;
        code = {c[3], c[1], c[0]};
        return longint'(1) << ((code + 1) % 8);
    endfunction

    // Behavioural reference, edge indexed from reset release.
    always @(posedge clk) begin
        if (rst) begin
            m_e = 0; m_next = 0; m_cur = 0; m_init = 0; m_cfg = 0; m_exp = 0;
        end else begin
            m_exp = 0;
            if (wr_en && wr_sel == 2'd0) begin
                m_cfg = wr_data[3:0] & 4'hB;
            end else if (wr_en && wr_sel == 2'd1) begin
                m_init = wr_data;
                m_cur  = wr_data;
                if (m_e % 16 == 15) m_next = m_e + 16 * mdiv(m_cfg);
                else m_next = m_e + (15 - m_e % 16) + 16 * mdiv(m_cfg);
            end else if (m_cur != 0 && m_e == m_next) begin
                m_cur  = m_cur - 1;
                m_exp  = (m_cur == 0);
                m_next = m_next + 16 * mdiv(m_cfg);
            end
            m_e = m_e + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && run) begin
            check("R8 expire", {31'd0, expire}, {31'd0, m_exp});
            if (rd_sel == 2'd2) check("R3 R5 R7 remaining", rd_data, m_cur);
            if (expire) n_exp++;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wr_aligned(input logic [31:0] d);
        @(posedge clk); #1;
        while (m_e % 16 != 15) begin @(posedge clk); #1; end
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        @(posedge clk); #1;
        rd_sel = sel;
        @(negedge clk);
        v = rd_data;
        @(posedge clk); #1;
        rd_sel = 2'd2;
    endtask

    task automatic wait_idle();
        while (m_cur != 0) @(posedge clk);
        repeat (20) @(posedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int base;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        run = 1'b1;
        // R10 reset state
        rd(2'd0, v); check("R10 cfg", v, 32'd0);
        rd(2'd1, v); check("R10 init", v, 32'd0);
        rd(2'd2, v); check("R10 remain", v, 32'd0);
        // R2 masking
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R2 cfg mask", v, 32'h0000_000B);
        // R1 divide by 1, unaligned load
        base = n_exp;
        @(posedge clk); #1;
        while (m_e % 16 != 4) begin @(posedge clk); #1; end
        wr(2'd1, 32'd5);
        rd(2'd1, v); check("R4 init readback", v, 32'd5);
        // R6 write to read-only count
        wr(2'd2, 32'h77);
        rd(2'd2, v); check("R6 remain unchanged", v, m_cur);
        // R11 empty slot
        wr(2'd3, 32'hABCD);
        rd(2'd3, v); check("R11 empty reads zero", v, 32'd0);
        rd(2'd0, v); check("R11 cfg untouched", v, 32'h0000_000B);
        wait_idle();
        check("R8 one pulse div1", n_exp - base, 1);
        // R1 divide by 2, aligned load
        wr(2'd0, 32'h0);
        base = n_exp;
        wr_aligned(32'd3);
        wait_idle();
        check("R5 R8 aligned expiry", n_exp - base, 1);
        // R4 reload mid-count cancels
        base = n_exp;
        wr(2'd1, 32'd10);
        repeat (45) @(posedge clk);
        wr(2'd1, 32'd2);
        wait_idle();
        check("R4 reload single expiry", n_exp - base, 1);
        // R9 zero load stops
        base = n_exp;
        wr(2'd1, 32'd4);
        repeat (20) @(posedge clk);
        wr(2'd1, 32'd0);
        repeat (200) @(posedge clk);
        rd(2'd2, v); check("R9 stopped", v, 32'd0);
        check("R9 no expiry", n_exp - base, 0);
        // R1 code 011 -> divide by 16
        wr(2'd0, 32'h3);
        base = n_exp;
        wr(2'd1, 32'd2);
        wait_idle();
        check("R1 div16 expiry", n_exp - base, 1);
        // R1 code 110 -> divide by 128
        wr(2'd0, 32'h0000_000A);
        rd(2'd0, v); check("R1 cfg code 110", v, 32'h0000_000A);
        base = n_exp;
        wr_aligned(32'd2);
        wait_idle();
        check("R1 div128 expiry", n_exp - base, 1);
        // R4 full-width load
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R4 full width", v, 32'hFFFF_FFFF);
        wr(2'd1, 32'd0);
        repeat (5) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule